// File: doc/BRIEF.md
# Scaled-Rate Model Fast Clock

This block keeps a model-time clock (minutes, hours, days) that runs faster than real time by a programmable ratio. A parameterised divider turns the system clock into a one-per-second strobe. On every strobe, a sub-minute phase accumulator adds the current rate. Each time the accumulator passes a whole minute, it sends a minute carry to the time-of-day counters. A rate of zero stops model time.

Software or a message handler loads the clock through a single write strobe. One write sets the rate, the encoded minute and hour, the day count, a control byte and a two-part setter identity. A sync input realigns the sub-minute phase, but only when the control byte marks the clock data as valid. The minute and hour fields are shown in their encoded form, which is 256 minus the value, modulo 256. Every readback field comes straight from flops or from a negation of a flop.

Top module: `fast_clock_core`

## Requirements
- R1: After reset, all outputs are zero: rate, fraction, encoded minute and hour, days, control byte, valid flag and both setter-ID parts.
- R2: A cycle with `wr_en` high does four things on the next edge: it loads rate, control and both ID parts from the inputs, loads minute, hour and days, and clears the fraction. It takes priority over a second strobe and over `sync` in the same cycle.
- R3: `min_enc_o` equals (256 − minute) mod 256 and `hour_enc_o` equals (256 − hour) mod 256. On a write, minute = ((256 − `wr_min_enc`) mod 256) mod 60 and hour = ((256 − `wr_hour_enc`) mod 256) mod 24.
- R4: The second strobe fires once every `TICKS_PER_SEC` system cycles, counting from reset. On each strobe the fraction becomes (fraction + rate) mod 60, and the minute advances by (fraction + rate) div 60, which can be 0 to 3.
- R5: While the rate is 0, the fraction, minute, hour and days do not change on a strobe.
- R6: When the minute passes 59, it wraps modulo 60 and the hour increments.
- R7: When the hour wraps from 23 to 0, days increments by one. Days wraps from 2^`DAY_W` − 1 to 0.
- R8: When `sync` is high, the current control byte has bit 6 set and no write is pending, the fraction clears on the next edge and no minute advance occurs in that cycle. When control bit 6 is 0, `sync` has no effect.
- R9: The setter-ID outputs hold the last written values and read 0,0 until the first write.
- R10: `valid_o` equals bit 6 of the stored control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load all clock fields |
| wr_rate | input | 7 | Rate to load (0 = frozen) |
| wr_min_enc | input | 8 | Encoded minute to load |
| wr_hour_enc | input | 8 | Encoded hour to load |
| wr_days | input | DAY_W | Day count to load |
| wr_ctrl | input | 7 | Control byte to load (bit 6 = valid) |
| wr_id_lo | input | 7 | Setter identity, low part |
| wr_id_hi | input | 7 | Setter identity, high part |
| sync | input | 1 | Realign the sub-minute phase |
| rate_o | output | 7 | Stored rate |
| frac_o | output | 6 | Sub-minute fraction, 0..59 |
| min_enc_o | output | 8 | Encoded minute |
| hour_enc_o | output | 8 | Encoded hour |
| days_o | output | DAY_W | Day count |
| ctrl_o | output | 7 | Stored control byte |
| valid_o | output | 1 | Clock data valid |
| id_lo_o | output | 7 | Last setter, low part |
| id_hi_o | output | 7 | Last setter, high part |

## Verification
The bench runs rate 127 long enough to produce several minute carries in one strobe. A design that emits only one carry per second would fall behind the reference minute there. It starts runs at 23:58 and at 23:59 with the day count at its maximum. These runs expose a missed hour carry, a day counter that fails to wrap, and an encoding that is off by one at minute 0. It places a write exactly on a strobe cycle and a sync with the valid bit cleared. A design with the wrong priority would advance time or clear the phase there. It also writes encoded values that are out of range, which exposes a decoder that skips the modulo.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int MIN_PER_HOUR  = 60;
  localparam int HRS_PER_DAY   = 24;
  localparam int RATE_W        = 7;
  localparam int ENC_W         = 8;
  localparam int ID_W          = 7;
  localparam int CTRL_W        = 7;
  localparam int VALID_BIT     = 6;
  localparam int MIN_W         = 6;
  localparam int HOUR_W        = 5;
  localparam int FRAC_W        = 6;
  localparam int CARRY_W       = 2;
  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [ENC_W-1:0]  enc_t;
endpackage

// File: rtl/fc_second_div.sv
module fc_second_div #(
  parameter int TICKS_PER_SEC = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic sec_o
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;

  assign sec_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (sec_o) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
endmodule

// File: rtl/fc_frac_acc.sv
module fc_frac_acc
  import fc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_i,
  input  rate_t              rate_i,
  input  logic               clear_i,
  output logic [FRAC_W-1:0]  frac_o,
  output logic [CARRY_W-1:0] carry_o
);
  localparam int SUM_W = ENC_W;
  localparam logic [SUM_W-1:0] MODV = SUM_W'(MIN_PER_HOUR);

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic [SUM_W-1:0] quo;

  always_comb begin
    sum = SUM_W'(frac_o) + SUM_W'(rate_i);
    rem = sum % MODV;
    quo = sum / MODV;
    carry_o = (sec_i && !clear_i) ? CARRY_W'(quo) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) frac_o <= '0;
    else if (sec_i)     frac_o <= FRAC_W'(rem);
  end

  // R4
  frac_range_chk: assert property (@(posedge clk) disable iff (rst)
    frac_o < FRAC_W'(MIN_PER_HOUR));
  // R5
  frac_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_i == '0 && !clear_i) |=> $stable(frac_o));
endmodule

// File: rtl/fc_tod.sv
module fc_tod
  import fc_pkg::*;
#(
  parameter int DAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [MIN_W-1:0]   ld_min_i,
  input  logic [HOUR_W-1:0]  ld_hour_i,
  input  logic [DAY_W-1:0]   ld_days_i,
  input  logic [CARRY_W-1:0] adv_i,
  output logic [MIN_W-1:0]   min_o,
  output logic [HOUR_W-1:0]  hour_o,
  output logic [DAY_W-1:0]   days_o
);
  localparam logic [MIN_W:0]    MIN_LIM  = (MIN_W+1)'(MIN_PER_HOUR);
  localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(HRS_PER_DAY - 1);

  logic [MIN_W:0] msum;
  logic           hcarry;

  always_comb begin
    msum   = {1'b0, min_o} + (MIN_W+1)'(adv_i);
    hcarry = (msum >= MIN_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_o  <= '0;
      hour_o <= '0;
      days_o <= '0;
    end else if (load_i) begin
      min_o  <= ld_min_i;
      hour_o <= ld_hour_i;
      days_o <= ld_days_i;
    end else if (adv_i != '0) begin
      min_o <= hcarry ? MIN_W'(msum - MIN_LIM) : MIN_W'(msum);
      if (hcarry) begin
        if (hour_o == HOUR_TOP) begin
          hour_o <= '0;
          days_o <= days_o + 1'b1;
        end else begin
          hour_o <= hour_o + 1'b1;
        end
      end
    end
  end

  // R6
  min_range_chk: assert property (@(posedge clk) disable iff (rst)
    min_o < MIN_W'(MIN_PER_HOUR));
  // R6
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    hour_o <= HOUR_TOP);
  // R7
  day_roll_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && hour_o == HOUR_TOP && hcarry && adv_i != '0) |=>
      (hour_o == '0 && days_o == $past(days_o) + 1'b1));
  // R5
  tod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_i == '0) |=> ($stable(min_o) && $stable(hour_o) && $stable(days_o)));
endmodule

// File: rtl/fast_clock_core.sv
module fast_clock_core
  import fc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 125_000_000,
  parameter int DAY_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [6:0]        wr_rate,
  input  logic [7:0]        wr_min_enc,
  input  logic [7:0]        wr_hour_enc,
  input  logic [DAY_W-1:0]  wr_days,
  input  logic [6:0]        wr_ctrl,
  input  logic [6:0]        wr_id_lo,
  input  logic [6:0]        wr_id_hi,
  input  logic              sync,
  output logic [6:0]        rate_o,
  output logic [5:0]        frac_o,
  output logic [7:0]        min_enc_o,
  output logic [7:0]        hour_enc_o,
  output logic [DAY_W-1:0]  days_o,
  output logic [6:0]        ctrl_o,
  output logic              valid_o,
  output logic [6:0]        id_lo_o,
  output logic [6:0]        id_hi_o
);
  localparam enc_t MIN_MOD  = ENC_W'(MIN_PER_HOUR);
  localparam enc_t HOUR_MOD = ENC_W'(HRS_PER_DAY);

  logic               sec;
  logic               phase_clr;
  logic [CARRY_W-1:0] adv;
  logic [MIN_W-1:0]   minute;
  logic [HOUR_W-1:0]  hour;
  logic [MIN_W-1:0]   ld_min;
  logic [HOUR_W-1:0]  ld_hour;
  enc_t               dec_min;
  enc_t               dec_hour;

  always_comb begin
    dec_min  = ENC_W'(0) - wr_min_enc;
    dec_hour = ENC_W'(0) - wr_hour_enc;
    ld_min   = MIN_W'(dec_min % MIN_MOD);
    ld_hour  = HOUR_W'(dec_hour % HOUR_MOD);
  end

  assign phase_clr = wr_en || (sync && ctrl_o[VALID_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_o  <= '0;
      ctrl_o  <= '0;
      id_lo_o <= '0;
      id_hi_o <= '0;
    end else if (wr_en) begin
      rate_o  <= wr_rate;
      ctrl_o  <= wr_ctrl;
      id_lo_o <= wr_id_lo;
      id_hi_o <= wr_id_hi;
    end
  end

  fc_second_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk   (clk),
    .rst   (rst),
    .sec_o (sec)
  );

  fc_frac_acc u_frac (
    .clk     (clk),
    .rst     (rst),
    .sec_i   (sec),
    .rate_i  (rate_o),
    .clear_i (phase_clr),
    .frac_o  (frac_o),
    .carry_o (adv)
  );

  fc_tod #(.DAY_W(DAY_W)) u_tod (
    .clk       (clk),
    .rst       (rst),
    .load_i    (wr_en),
    .ld_min_i  (ld_min),
    .ld_hour_i (ld_hour),
    .ld_days_i (wr_days),
    .adv_i     (adv),
    .min_o     (minute),
    .hour_o    (hour),
    .days_o    (days_o)
  );

  assign min_enc_o  = ENC_W'(0) - ENC_W'(minute);
  assign hour_enc_o = ENC_W'(0) - ENC_W'(hour);
  assign valid_o    = ctrl_o[VALID_BIT];

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rate_o == $past(wr_rate) && id_lo_o == $past(wr_id_lo)
               && id_hi_o == $past(wr_id_hi) && frac_o == '0));
  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sync && valid_o) |=> frac_o == '0);
  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(id_lo_o) && $stable(id_hi_o)));
  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_o == '0 && !wr_en) |=> ($stable(min_enc_o) && $stable(hour_enc_o)));
endmodule

// File: tb/fast_clock_core_tb.sv
module fast_clock_core_tb;
  localparam int T  = 4;
  localparam int DW = 8;

  logic clk = 0, rst = 1;
  logic wr_en = 0, sync = 0;
  logic [6:0] wr_rate = 0, wr_ctrl = 0, wr_id_lo = 0, wr_id_hi = 0;
  logic [7:0] wr_min_enc = 0, wr_hour_enc = 0;
  logic [DW-1:0] wr_days = 0;
  logic [6:0] rate_o, ctrl_o, id_lo_o, id_hi_o;
  logic [5:0] frac_o;
  logic [7:0] min_enc_o, hour_enc_o;
  logic [DW-1:0] days_o;
  logic valid_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  int m_div = 0, m_rate = 0, m_frac = 0, m_min = 0, m_hour = 0, m_days = 0;
  int m_ctrl = 0, m_idl = 0, m_idh = 0;

  always #4 clk = ~clk;

  fast_clock_core #(.TICKS_PER_SEC(T), .DAY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_rate(wr_rate),
    .wr_min_enc(wr_min_enc), .wr_hour_enc(wr_hour_enc), .wr_days(wr_days),
    .wr_ctrl(wr_ctrl), .wr_id_lo(wr_id_lo), .wr_id_hi(wr_id_hi), .sync(sync),
    .rate_o(rate_o), .frac_o(frac_o), .min_enc_o(min_enc_o), .hour_enc_o(hour_enc_o),
    .days_o(days_o), .ctrl_o(ctrl_o), .valid_o(valid_o), .id_lo_o(id_lo_o), .id_hi_o(id_hi_o)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_rate = 0; m_frac = 0; m_min = 0; m_hour = 0; m_days = 0;
      m_ctrl = 0; m_idl = 0; m_idh = 0;
    end else begin
      bit strobe;
      int total;
      strobe = (m_div == T - 1);
      m_div  = strobe ? 0 : m_div + 1;
      if (wr_en) begin
        m_rate = wr_rate; m_ctrl = wr_ctrl; m_idl = wr_id_lo; m_idh = wr_id_hi;
        m_frac = 0;
        m_min  = ((256 - wr_min_enc) % 256) % 60;
        m_hour = ((256 - wr_hour_enc) % 256) % 24;
        m_days = wr_days;
      end else if (sync && m_ctrl[6]) begin
        m_frac = 0;
      end else if (strobe) begin
        total  = m_frac + m_rate;
        m_frac = total % 60;
        total  = m_hour * 60 + m_min + total / 60;
        if (total >= 24 * 60) begin
          total  = total - 24 * 60;
          m_days = (m_days + 1) % (1 << DW);
        end
        m_hour = total / 60;
        m_min  = total % 60;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk(tag, "rate", rate_o, m_rate);
    chk(tag, "frac", frac_o, m_frac);
    chk("R3", "min_enc", min_enc_o, (256 - m_min) % 256);
    chk("R3", "hour_enc", hour_enc_o, (256 - m_hour) % 256);
    chk(tag, "days", days_o, m_days);
    chk("R10", "valid", valid_o, (m_ctrl >> 6) & 1);
    chk("R9", "id", {id_hi_o, id_lo_o}, (m_idh << 7) | m_idl);
  end

  task automatic do_write(input int rate, input int mn, input int hr, input int dy,
                          input int ctrl, input int il, input int ih);
    @(negedge clk);
    wr_en = 1; wr_rate = 7'(rate); wr_min_enc = 8'((256 - mn) % 256);
    wr_hour_enc = 8'((256 - hr) % 256); wr_days = DW'(dy);
    wr_ctrl = 7'(ctrl); wr_id_lo = 7'(il); wr_id_hi = 7'(ih);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk("R1", "reset rate", rate_o, 0);
    chk("R1", "reset min_enc", min_enc_o, 0);
    chk("R1", "reset hour_enc", hour_enc_o, 0);
    chk("R1", "reset days", days_o, 0);
    chk("R1", "reset ctrl", ctrl_o, 0);
    chk("R9", "reset id", {id_hi_o, id_lo_o}, 0);

    tag = "R2";
    do_write(10, 58, 23, 5, 7'h40, 3, 9);
    chk("R2", "loaded rate", rate_o, 10);
    chk("R3", "loaded min_enc 58", min_enc_o, 198);
    tag = "R6";
    run(20 * T);
    tag = "R7";
    chk("R7", "day after 23->0", days_o, 6);

    tag = "R4";
    do_write(127, 10, 4, 0, 7'h40, 1, 1);
    run(300 * T);
    chk("R4", "minute after 300s at 127", min_enc_o, (256 - ((10 + (300 * 127) / 60) % 60)) % 256);

    tag = "R5";
    do_write(0, 33, 12, 2, 7'h40, 2, 2);
    run(25 * T);
    chk("R5", "frozen minute", min_enc_o, 256 - 33);
    chk("R5", "frozen frac", frac_o, 0);

    tag = "R8";
    do_write(7, 0, 1, 0, 7'h40, 4, 4);
    run(3 * T);
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    chk("R8", "sync clears frac", frac_o, 0);
    do_write(7, 0, 1, 0, 7'h00, 4, 4);
    run(3 * T);
    @(negedge clk); sync = 1;
    @(negedge clk); sync = 0;
    chk("R8", "sync ignored when invalid frac", frac_o, m_frac);
    chk("R10", "valid cleared", valid_o, 0);

    tag = "R2";
    while (m_div != T - 1) @(negedge clk);
    wr_en = 1; wr_rate = 7'd59; wr_min_enc = 8'd0; wr_hour_enc = 8'd0;
    wr_days = '0; wr_ctrl = 7'h40; wr_id_lo = 7'd5; wr_id_hi = 7'd6;
    @(negedge clk); wr_en = 0;
    chk("R2", "write beats strobe frac", frac_o, 0);
    chk("R2", "write beats strobe min", min_enc_o, 0);

    tag = "R7";
    do_write(60, 59, 23, 255, 7'h40, 7, 7);
    run(2 * T);
    chk("R7", "days wrap", days_o, 0);
    chk("R7", "hour wrapped", hour_enc_o, 0);

    tag = "R3";
    @(negedge clk);
    wr_en = 1; wr_rate = 0; wr_min_enc = 8'd100; wr_hour_enc = 8'd3;
    wr_days = '0; wr_ctrl = 0; wr_id_lo = 0; wr_id_hi = 0;
    @(negedge clk); wr_en = 0;
    chk("R3", "decoded out-of-range minute", min_enc_o, (256 - (156 % 60)) % 256);
    chk("R3", "decoded out-of-range hour", hour_enc_o, (256 - (253 % 24)) % 256);
    run(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule